// File: doc/BRIEF.md
# Supervisory Reset Generator with Line-Activity Watchdog

This block drives one system reset output from three causes: a power-on interval after the power-good input is released, a digital low-supply flag from an external comparator, and a watchdog that monitors a serial data line. Any change of level on the monitored line restarts the watchdog. If the line holds one level, high or low, for the selected interval, the watchdog expires and the reset is pulsed. All three causes feed one shared stretch counter. As a result, a released reset always stays active for a known number of timebase ticks.

All timing counts a prescaled `tick` enable, so each interval is a tick-count parameter and a simulation can use small values. The watchdog interval comes from a two-bit configuration input. That input is expected to hold a static value, because it comes from settings that survive a power cycle. A parameter sets the polarity of the reset pin. The block has no data stream, so every pin is a plain level signal with no handshake.

Top module: `sup_reset_gen`

## Requirements
- R1: While `rst_n` is low, the reset output is asserted at once (asynchronously). After `rst_n` rises, the output stays asserted until `PON_TICKS` ticks have been counted.
- R2: With `ACTIVE_LOW`=1, an asserted reset drives `sys_reset` to 0. With `ACTIVE_LOW`=0, it drives `sys_reset` to 1.
- R3: When `low_supply`=1 is sampled on a clock edge, the output is asserted from that edge on and remains asserted while the flag stays 1.
- R4: After `low_supply` returns to 0, the output stays asserted for exactly `STRETCH_TICKS` further ticks, then releases.
- R5: `wd_line` passes through a two-flop synchronizer. A change between two successive synchronized samples restarts the watchdog count from zero, so a line that keeps toggling faster than the interval never causes a reset.
- R6: When the watchdog is enabled and the reset is released, each tick with no restart adds one to the count. On the tick that brings the count to the selected limit, the watchdog expires. From the next edge, the output is asserted for `STRETCH_TICKS` ticks.
- R7: `wd_sel` encodes the watchdog mode: 0 = off (never expires), 1 = `WD_SHORT_TICKS`, 2 = `WD_MID_TICKS`, 3 = `WD_LONG_TICKS`.
- R8: The watchdog count is held at zero while the reset output is asserted, so it always starts again from zero when the reset releases.
- R9: Only cycles with `tick`=1 move the power-on, stretch and watchdog counts. With `tick` low, a released output stays released and an asserted output stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-good / reset input, active low, asynchronous assert |
| tick | input | 1 | Prescaled timebase enable, one clock wide |
| low_supply | input | 1 | Digital low-supply flag, 1 = supply below trip point |
| wd_line | input | 1 | Monitored serial data line (asynchronous) |
| wd_sel | input | 2 | Watchdog mode: 0 off, 1 short, 2 mid, 3 long |
| sys_reset | output | 1 | System reset, polarity set by `ACTIVE_LOW` |

## Verification
The bench keeps a behavioural model of the tick counts and compares it with both polarity builds on every cycle. It therefore catches a stretch that is one tick long or short. It also catches a design that counts clocks instead of ticks. The bench lets the line stop toggling just short of the short interval and just past it. A design that ignored the synchronizer delay, or restarted only on rising edges, would show a reset early or late. The bench holds the line steady under the long setting for longer than the short interval, and under the off setting for a long time. A bad decode of `wd_sel` would produce a spurious reset there. Other runs stop `tick` during a stretch, assert `rst_n` in mid-run, and follow a watchdog reset with a steady line. These catch a count that keeps running without ticks and a watchdog that keeps counting through its own reset pulse.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    WD_OFF   = 2'd0,
    WD_SHORT = 2'd1,
    WD_MID   = 2'd2,
    WD_LONG  = 2'd3
  } wd_sel_e;
endpackage

// File: rtl/line_activity.sv
// Synchronizes the monitored line and flags any change between samples.
module line_activity #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic toggled
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   prev;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= line_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2:0], line_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[SYNC_STAGES-1];
  end

  assign toggled = chain[SYNC_STAGES-1] ^ prev;
endmodule

// File: rtl/wd_timer.sv
// Counts ticks of line inactivity and flags expiry of the selected interval.
module wd_timer
  import sup_pkg::*;
#(
  parameter int T_SHORT = 200,
  parameter int T_MID   = 600,
  parameter int T_LONG  = 1400,
  parameter int CNT_W   = 11
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    hold,
  input  logic    restart,
  input  wd_sel_e sel,
  output logic    expire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             enabled;
  logic [CNT_W:0]   cnt_inc;

  always_comb begin
    case (sel)
      WD_SHORT: limit = CNT_W'(T_SHORT);
      WD_MID:   limit = CNT_W'(T_MID);
      WD_LONG:  limit = CNT_W'(T_LONG);
      default:  limit = '0;
    endcase
  end

  assign enabled = (sel != WD_OFF);
  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign expire  = enabled && tick && !hold && !restart &&
                   (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  cnt <= '0;
    else if (hold || !enabled || restart || expire) cnt <= '0;
    else if (tick)                               cnt <= cnt_inc[CNT_W-1:0];
  end
endmodule

// File: rtl/rst_stretch.sv
// Shared stretch counter: power-on load, low-supply hold, watchdog load.
module rst_stretch #(
  parameter int PON_TICKS     = 250,
  parameter int STRETCH_TICKS = 250,
  parameter int REM_W         = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic low_supply,
  input  logic wd_expire,
  output logic active
);
  logic [REM_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     remain <= REM_W'(PON_TICKS);
    else if (low_supply || wd_expire) remain <= REM_W'(STRETCH_TICKS);
    else if (tick && remain != '0)  remain <= remain - 1'b1;
  end

  assign active = (remain != '0);
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
  import sup_pkg::*;
#(
  parameter bit ACTIVE_LOW     = 1'b1,
  parameter int PON_TICKS      = 250,
  parameter int STRETCH_TICKS  = 250,
  parameter int WD_SHORT_TICKS = 200,
  parameter int WD_MID_TICKS   = 600,
  parameter int WD_LONG_TICKS  = 1400,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       low_supply,
  input  logic       wd_line,
  input  logic [1:0] wd_sel,
  output logic       sys_reset
);
  localparam int REM_MAX = (PON_TICKS > STRETCH_TICKS) ? PON_TICKS : STRETCH_TICKS;
  localparam int REM_W   = $clog2(REM_MAX + 1);
  localparam int WD_M01  = (WD_SHORT_TICKS > WD_MID_TICKS) ? WD_SHORT_TICKS : WD_MID_TICKS;
  localparam int WD_MAX  = (WD_M01 > WD_LONG_TICKS) ? WD_M01 : WD_LONG_TICKS;
  localparam int CNT_W   = $clog2(WD_MAX + 1);

  logic line_toggled;
  logic wd_expire;
  logic rst_active;

  line_activity #(.SYNC_STAGES(SYNC_STAGES)) u_act (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (wd_line),
    .toggled (line_toggled)
  );

  wd_timer #(
    .T_SHORT (WD_SHORT_TICKS),
    .T_MID   (WD_MID_TICKS),
    .T_LONG  (WD_LONG_TICKS),
    .CNT_W   (CNT_W)
  ) u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .hold    (rst_active),
    .restart (line_toggled),
    .sel     (wd_sel_e'(wd_sel)),
    .expire  (wd_expire)
  );

  rst_stretch #(
    .PON_TICKS     (PON_TICKS),
    .STRETCH_TICKS (STRETCH_TICKS),
    .REM_W         (REM_W)
  ) u_str (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .low_supply (low_supply),
    .wd_expire  (wd_expire),
    .active     (rst_active)
  );

  generate
    if (ACTIVE_LOW) begin : g_low
      assign sys_reset = ~rst_active;
    end else begin : g_high
      assign sys_reset = rst_active;
    end
  endgenerate
endmodule

// File: rtl/sup_reset_chk.sv
module sup_reset_chk #(
  parameter bit ACTIVE_LOW = 1'b1,
  parameter int PON_TICKS  = 250
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic low_supply,
  input logic sys_reset,
  input logic wd_expire
);
  logic        asserted;
  int unsigned ticks_since;

  assign asserted = ACTIVE_LOW ? !sys_reset : sys_reset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  ticks_since <= 0;
    else if (tick && ticks_since < PON_TICKS)    ticks_since <= ticks_since + 1;
  end

  // R1
  pon_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ticks_since < PON_TICKS) |-> asserted);

  // R3
  low_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_supply |=> asserted);

  // R4
  recovery_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(low_supply) |-> asserted);

  // R6
  wd_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> asserted);

  // R9
  no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !low_supply) |=> $stable(sys_reset));
endmodule

bind sup_reset_gen sup_reset_chk #(
  .ACTIVE_LOW (ACTIVE_LOW),
  .PON_TICKS  (PON_TICKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .low_supply (low_supply),
  .sys_reset  (sys_reset),
  .wd_expire  (wd_expire)
);

// File: tb/test_sup_reset_gen.sv
`timescale 1ns/100ps
module test_sup_reset_gen;
  localparam int PON = 20;
  localparam int STR = 8;
  localparam int WS  = 10;
  localparam int WM  = 25;
  localparam int WL  = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       low_supply = 1'b0;
  logic       wd_line = 1'b0;
  logic [1:0] wd_sel = 2'd0;
  logic       rst_lo, rst_hi;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit tick_en = 1'b1;
  int tog_per = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  sup_reset_gen #(.ACTIVE_LOW(1'b1), .PON_TICKS(PON), .STRETCH_TICKS(STR),
    .WD_SHORT_TICKS(WS), .WD_MID_TICKS(WM), .WD_LONG_TICKS(WL)) i_sup_reset_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .low_supply(low_supply),
    .wd_line(wd_line), .wd_sel(wd_sel), .sys_reset(rst_lo));

  sup_reset_gen #(.ACTIVE_LOW(1'b0), .PON_TICKS(PON), .STRETCH_TICKS(STR),
    .WD_SHORT_TICKS(WS), .WD_MID_TICKS(WM), .WD_LONG_TICKS(WL)) i_sup_reset_gen_hi (
    .clk(clk), .rst_n(rst_n), .tick(tick), .low_supply(low_supply),
    .wd_line(wd_line), .wd_sel(wd_sel), .sys_reset(rst_hi));

  // Behavioural reference: sampled-line history, idle tick count, remaining stretch.
  int m_hist[$] = '{0, 0, 0};
  int m_idle = 0;
  int m_rem = PON;

  function automatic int limit_of(input logic [1:0] s);
    case (s)
      2'd1: return WS;
      2'd2: return WM;
      2'd3: return WL;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hist = '{0, 0, 0};
      m_idle = 0;
      m_rem  = PON;
    end else begin
      int  lim;
      bit  moved, fire;
      lim   = limit_of(wd_sel);
      moved = (m_hist[1] != m_hist[2]);
      fire  = (lim > 0) && tick && !moved && (m_rem == 0) && (m_idle + 1 >= lim);
      if (m_rem != 0 || lim == 0 || moved || fire) m_idle = 0;
      else if (tick) m_idle = m_idle + 1;
      if (low_supply || fire) m_rem = STR;
      else if (tick && m_rem > 0) m_rem = m_rem - 1;
      m_hist.push_front(int'(wd_line));
      void'(m_hist.pop_back());
    end
  end

  // Per-cycle comparison of both polarity builds (R2 covers polarity).
  always @(negedge clk) begin
    bit exp_act;
    exp_act = (m_rem != 0);
    checks++;
    if (rst_lo !== ~exp_act) begin
      failures++;
      $display("FAIL %s (R2 low-active) t=%0t sys_reset=%b expected=%b", cur_req, $time, rst_lo, ~exp_act);
    end
    checks++;
    if (rst_hi !== exp_act) begin
      failures++;
      $display("FAIL %s (R2 high-active) t=%0t sys_reset=%b expected=%b", cur_req, $time, rst_hi, exp_act);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      cyc++;
      tick = tick_en && (cyc % 2 == 0);
      if (tog_per > 0 && cyc % tog_per == 0) wd_line = ~wd_line;
    end
  endtask

  task automatic expect_rst(input bit exp_act, input string req);
    @(negedge clk);
    #0.1;
    checks++;
    if ((rst_lo !== ~exp_act) || (rst_hi !== exp_act)) begin
      failures++;
      $display("FAIL %s directed t=%0t lo=%b hi=%b expected asserted=%b", req, $time, rst_lo, rst_hi, exp_act);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired before completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    step(5);
    expect_rst(1'b1, "R1");
    rst_n = 1'b1;
    step(10);
    expect_rst(1'b1, "R1");
    step(40);
    expect_rst(1'b0, "R1");

    // R3 / R4: low-supply hold and recovery stretch
    cur_req = "R3";
    low_supply = 1'b1;
    step(1);
    expect_rst(1'b1, "R3");
    step(20);
    expect_rst(1'b1, "R3");
    cur_req = "R4";
    low_supply = 1'b0;
    step(10);
    expect_rst(1'b1, "R4");
    step(20);
    expect_rst(1'b0, "R4");

    // R5: toggling line keeps short watchdog quiet
    cur_req = "R5";
    wd_sel = 2'd1;
    tog_per = 6;
    step(100);
    expect_rst(1'b0, "R5");

    // R6: steady line expires the short interval
    cur_req = "R6";
    tog_per = 0;
    step(14);
    expect_rst(1'b0, "R6");
    step(16);
    expect_rst(1'b1, "R6");

    // R8: after release the count starts over, line still steady
    cur_req = "R8";
    step(80);

    // R7: long setting tolerates longer idle, then expires
    cur_req = "R7";
    tog_per = 4;
    wd_sel = 2'd3;
    step(60);
    tog_per = 0;
    step(70);
    expect_rst(1'b0, "R7");
    step(40);
    expect_rst(1'b1, "R7");
    step(40);
    // mid setting
    wd_sel = 2'd2;
    tog_per = 8;
    step(40);
    tog_per = 0;
    step(120);
    // off setting: no watchdog resets at all
    wd_sel = 2'd0;
    step(40);
    step(200);
    expect_rst(1'b0, "R7");

    // R9: no ticks, nothing moves
    cur_req = "R9";
    wd_sel = 2'd1;
    tick_en = 1'b0;
    step(100);
    expect_rst(1'b0, "R9");
    low_supply = 1'b1;
    step(3);
    low_supply = 1'b0;
    step(50);
    expect_rst(1'b1, "R9");
    tick_en = 1'b1;
    tog_per = 4;
    step(40);
    expect_rst(1'b0, "R9");

    // R1: asynchronous reset in mid-run
    cur_req = "R1";
    #1;
    rst_n = 1'b0;
    #0.5;
    checks++;
    if (rst_lo !== 1'b0 || rst_hi !== 1'b1) begin
      failures++;
      $display("FAIL R1 async t=%0t lo=%b hi=%b expected asserted", $time, rst_lo, rst_hi);
    end
    step(4);
    rst_n = 1'b1;
    step(60);
    expect_rst(1'b0, "R1");
    finish_run();
  end
endmodule